// File: doc/BRIEF.md
# Host Controller Command and Status Registers

This block holds the command and status registers of a USB host controller. Software reaches them through a 32-bit dword register port. The command register starts and stops the controller. It can also request a full controller reset or a light reset, and both reset bits clear themselves when their sequence ends. The status register reports several conditions: whether the controller has halted, whether it is not yet ready after a reset, a fatal error, an event interrupt, a port change, and an internal controller error.

Other parts of the controller raise error, event and port-change conditions through single-cycle inputs. The block returns three things to them: a run-enable level, a core reset level that is high during either reset sequence, and an accept signal that gates doorbell writes. Run/stop and the halted flag are linked through a fixed halt delay. A fatal error withdraws run/stop by itself. After a full reset, a not-ready window blocks every register and doorbell write.

Top module: `hc_cmdsts`

## Requirements
- R1: After `rst`, the command register (address 0) reads 0x0 and the status register (address 1) reads 0x801: halted flag bit 0 = 1 and not-ready bit 11 = 1. `run_enable` and `core_rst` are 0.
- R2: Not-ready (status bit 11) clears on the 32nd clock edge after the last edge with `rst` high. The same 32-edge window applies after a full reset sequence ends. While not-ready is set, register writes have no effect, `db_accept` is 0, and `run_enable` is 0.
- R3: Writing command bit 0 (run/stop) as 1 while halted raises `run_enable` one clock after the write edge. The halted flag clears on that same clock.
- R4: Writing command bit 0 as 0 drops `run_enable` one clock after the write edge. The halted flag then sets 16 clocks after `run_enable` has dropped.
- R5: A `fatal_evt` pulse sets status bit 2 and clears command bit 0 on the same edge. It wins over a same-cycle write that sets bit 0. The halt sequence of R4 then follows.
- R6: `event_evt` sets status bit 3 and `port_evt` sets status bit 4. Both flags stay set until software clears them.
- R7: Status bits 2, 3 and 4 are write-1-to-clear, and writing 0 to them leaves them unchanged. If a new event and a clear of the same bit arrive in the same cycle, the event wins.
- R8: Writing command bit 1 starts a full reset. Bit 1 reads 1 for 8 clocks and then reads 0. During the sequence `core_rst` is 1, not-ready is 1, and the controller is halted. All flags, including bit 12, are cleared. R2's not-ready window follows the sequence.
- R9: Writing command bit 7 (when bit 1 is 0) starts a light reset. Bit 7 reads 1 for 8 clocks and then reads 0. It halts the controller at the write edge and clears the command register and status bits 2–4. `core_rst` is 1 during the sequence. Not-ready stays 0 and status bit 12 is kept.
- R10: Command bits 4–6 and 12–31 are reserved. They read 0 whatever is written. Bits 2, 3 and 8–11 are plain storage and read back what was written.
- R11: `hce_evt` sets status bit 12. Writing 1 to bit 12 does not clear it, and a light reset does not clear it either; only a full reset or `rst` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write dword index (0 command, 1 status) |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read dword index |
| reg_rdata | output | 32 | Read data, combinational |
| fatal_evt | input | 1 | Fatal error pulse |
| event_evt | input | 1 | Event interrupt pulse |
| port_evt | input | 1 | Port change pulse |
| hce_evt | input | 1 | Internal controller error pulse |
| db_req | input | 1 | Doorbell write request |
| db_accept | output | 1 | Doorbell write accepted |
| run_enable | output | 1 | Controller may run |
| core_rst | output | 1 | Reset level for controller core during a reset sequence |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a fatal error pulse and a command write that sets run/stop. The bench drives both in one cycle, then confirms that run/stop reads 0, the fatal flag reads 1, and `run_enable` never rises. The second pair is a write-1-to-clear of one flag and a new event on that flag, again in one cycle. The bench checks that the targeted flag stays set and that a different flag cleared in the same write does go to 0.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

    localparam int DW = 32;

    // command bit positions
    localparam int CMD_RUN_B   = 0;
    localparam int CMD_FRST_B  = 1;
    localparam int CMD_LRST_B  = 7;
    // status bit positions
    localparam int STS_HALT_B  = 0;
    localparam int STS_FATAL_B = 2;
    localparam int STS_EVT_B   = 3;
    localparam int STS_PORT_B  = 4;
    localparam int STS_NRDY_B  = 11;
    localparam int STS_HCE_B   = 12;

    // plain storage bits of the command register: 0, 2, 3, 8..11
    localparam logic [DW-1:0] CMD_STORE_MASK = 32'h0000_0F0D;

    localparam int IDX_CMD = 0;
    localparam int IDX_STS = 1;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FULL  = 2'd1,
        SEQ_LIGHT = 2'd2,
        SEQ_WAIT  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        RUN_HALTED   = 2'd0,
        RUN_ACTIVE   = 2'd1,
        RUN_DRAINING = 2'd2
    } run_state_e;

    typedef struct packed {
        logic hce;
        logic port;
        logic evt;
        logic fatal;
    } flags_t;

    function automatic logic [DW-1:0] cmd_view(input logic [DW-1:0] store,
                                               input logic full_busy,
                                               input logic light_busy);
        logic [DW-1:0] v;
        v = store & CMD_STORE_MASK;
        v[CMD_FRST_B] = full_busy;
        v[CMD_LRST_B] = light_busy;
        return v;
    endfunction

    function automatic logic [DW-1:0] sts_view(input flags_t f,
                                               input logic halted,
                                               input logic nrdy);
        logic [DW-1:0] v;
        v = '0;
        v[STS_HALT_B]  = halted;
        v[STS_FATAL_B] = f.fatal;
        v[STS_EVT_B]   = f.evt;
        v[STS_PORT_B]  = f.port;
        v[STS_NRDY_B]  = nrdy;
        v[STS_HCE_B]   = f.hce;
        return v;
    endfunction

endpackage

// File: rtl/hcs_reset_seq.sv
module hcs_reset_seq
    import hcs_pkg::*;
#(
    parameter int FRST_CYCLES = 8,
    parameter int LRST_CYCLES = 8,
    parameter int NRDY_CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start_full,
    input  logic start_light,
    output logic full_busy,
    output logic light_busy,
    output logic not_ready
);
    localparam int MAXC = (FRST_CYCLES > LRST_CYCLES) ?
                          ((FRST_CYCLES > NRDY_CYCLES) ? FRST_CYCLES : NRDY_CYCLES) :
                          ((LRST_CYCLES > NRDY_CYCLES) ? LRST_CYCLES : NRDY_CYCLES);
    localparam int CW = $clog2(MAXC) + 1;
    localparam logic [CW-1:0] F_LAST = CW'(FRST_CYCLES - 1);
    localparam logic [CW-1:0] L_LAST = CW'(LRST_CYCLES - 1);
    localparam logic [CW-1:0] N_LAST = CW'(NRDY_CYCLES - 1);

    seq_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q + 1'b1;
        unique case (st_q)
            SEQ_IDLE: begin
                cnt_d = '0;
                if (start_full)       st_d = SEQ_FULL;
                else if (start_light) st_d = SEQ_LIGHT;
            end
            SEQ_FULL: if (cnt_q == F_LAST) begin
                st_d  = SEQ_WAIT;
                cnt_d = '0;
            end
            SEQ_LIGHT: if (cnt_q == L_LAST) begin
                st_d  = SEQ_IDLE;
                cnt_d = '0;
            end
            SEQ_WAIT: if (cnt_q == N_LAST) begin
                st_d  = SEQ_IDLE;
                cnt_d = '0;
            end
            default: st_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SEQ_WAIT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign full_busy  = (st_q == SEQ_FULL);
    assign light_busy = (st_q == SEQ_LIGHT);
    assign not_ready  = (st_q == SEQ_FULL) || (st_q == SEQ_WAIT);

    // R8: a finished full reset hands over to the not-ready window
    assert_wait_after_full_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(full_busy) |-> not_ready);
    // R9: a light reset never leaves the block not-ready
    assert_light_keeps_ready_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(light_busy) |-> !not_ready);

endmodule

// File: rtl/hcs_run_ctl.sv
module hcs_run_ctl
    import hcs_pkg::*;
#(
    parameter int HALT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic force_halt,
    input  logic run_cmd,
    output logic run_enable,
    output logic halted
);
    localparam int CW = $clog2(HALT_CYCLES) + 1;
    localparam logic [CW-1:0] H_LAST = CW'(HALT_CYCLES - 1);

    run_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = '0;
        unique case (st_q)
            RUN_HALTED:   if (run_cmd) st_d = RUN_ACTIVE;
            RUN_ACTIVE:   if (!run_cmd) st_d = RUN_DRAINING;
            RUN_DRAINING: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == H_LAST) begin
                    st_d  = RUN_HALTED;
                    cnt_d = '0;
                end
            end
            default: st_d = RUN_HALTED;
        endcase
        if (force_halt) begin
            st_d  = RUN_HALTED;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RUN_HALTED;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign run_enable = (st_q == RUN_ACTIVE);
    assign halted     = (st_q == RUN_HALTED);

    // R4: a withdrawn run/stop stops the controller on the next clock
    assert_stop_next_R4: assert property (@(posedge clk) disable iff (rst)
        !run_cmd |=> !run_enable);
    // R9: any reset sequence leaves the controller halted
    assert_force_halts_R9: assert property (@(posedge clk) disable iff (rst)
        force_halt |=> halted);

endmodule

// File: rtl/hcs_sts_flags.sv
module hcs_sts_flags
    import hcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_soft,
    input  logic       clr_hard,
    input  logic       set_fatal,
    input  logic       set_evt,
    input  logic       set_port,
    input  logic       set_hce,
    input  logic       w1c_en,
    input  logic [2:0] w1c_bits,
    output flags_t     flags
);
    flags_t f_q, f_d;
    logic [2:0] clr;

    assign clr = w1c_en ? w1c_bits : 3'b000;

    always_comb begin
        f_d.fatal = (f_q.fatal & ~clr[0]) | set_fatal;
        f_d.evt   = (f_q.evt   & ~clr[1]) | set_evt;
        f_d.port  = (f_q.port  & ~clr[2]) | set_port;
        f_d.hce   = f_q.hce | set_hce;
        if (clr_soft) begin
            f_d.fatal = 1'b0;
            f_d.evt   = 1'b0;
            f_d.port  = 1'b0;
        end
        if (clr_hard) f_d.hce = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    assign flags = f_q;

    // R6: an event outside a reset sequence is always recorded
    assert_evt_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (set_evt && !clr_soft) |=> flags.evt);
    // R11: the internal error flag is only lost through a full reset
    assert_hce_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (flags.hce && !clr_hard) |=> flags.hce);

endmodule

// File: rtl/hc_cmdsts.sv
module hc_cmdsts
    import hcs_pkg::*;
#(
    parameter int AW          = 2,
    parameter int FRST_CYCLES = 8,
    parameter int LRST_CYCLES = 8,
    parameter int NRDY_CYCLES = 32,
    parameter int HALT_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_waddr,
    input  logic [31:0]   reg_wdata,
    input  logic [AW-1:0] reg_raddr,
    output logic [31:0]   reg_rdata,
    input  logic          fatal_evt,
    input  logic          event_evt,
    input  logic          port_evt,
    input  logic          hce_evt,
    input  logic          db_req,
    output logic          db_accept,
    output logic          run_enable,
    output logic          core_rst
);
    localparam logic [AW-1:0] A_CMD = AW'(IDX_CMD);
    localparam logic [AW-1:0] A_STS = AW'(IDX_STS);

    logic full_busy, light_busy, not_ready, halted;
    logic wr_ok, wr_cmd, wr_sts, start_full, start_light;
    logic seq_clear, hard_clear;
    logic [DW-1:0] cmd_q, cmd_d;
    flags_t flags;

    assign wr_ok       = reg_wr && !not_ready && !light_busy;
    assign wr_cmd      = wr_ok && (reg_waddr == A_CMD);
    assign wr_sts      = wr_ok && (reg_waddr == A_STS);
    assign start_full  = wr_cmd && reg_wdata[CMD_FRST_B];
    assign start_light = wr_cmd && reg_wdata[CMD_LRST_B] && !reg_wdata[CMD_FRST_B];
    assign seq_clear   = start_full || start_light || full_busy || light_busy;
    assign hard_clear  = start_full || full_busy;

    always_comb begin
        cmd_d = cmd_q;
        if (wr_cmd) cmd_d = reg_wdata & CMD_STORE_MASK;
        if (fatal_evt) cmd_d[CMD_RUN_B] = 1'b0;
        if (seq_clear) cmd_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd_d;
    end

    hcs_reset_seq #(
        .FRST_CYCLES(FRST_CYCLES),
        .LRST_CYCLES(LRST_CYCLES),
        .NRDY_CYCLES(NRDY_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_full (start_full),
        .start_light(start_light),
        .full_busy  (full_busy),
        .light_busy (light_busy),
        .not_ready  (not_ready)
    );

    hcs_run_ctl #(
        .HALT_CYCLES(HALT_CYCLES)
    ) u_run (
        .clk       (clk),
        .rst       (rst),
        .force_halt(seq_clear),
        .run_cmd   (cmd_q[CMD_RUN_B]),
        .run_enable(run_enable),
        .halted    (halted)
    );

    hcs_sts_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .clr_soft (seq_clear),
        .clr_hard (hard_clear),
        .set_fatal(fatal_evt),
        .set_evt  (event_evt),
        .set_port (port_evt),
        .set_hce  (hce_evt),
        .w1c_en   (wr_sts),
        .w1c_bits (reg_wdata[STS_PORT_B:STS_FATAL_B]),
        .flags    (flags)
    );

    always_comb begin
        if (reg_raddr == A_CMD)      reg_rdata = cmd_view(cmd_q, full_busy, light_busy);
        else if (reg_raddr == A_STS) reg_rdata = sts_view(flags, halted, not_ready);
        else                         reg_rdata = '0;
    end

    assign db_accept = db_req && !not_ready;
    assign core_rst  = full_busy || light_busy;

    // R5: a fatal error withdraws run/stop on the same edge
    assert_fatal_stops_R5: assert property (@(posedge clk) disable iff (rst)
        fatal_evt |=> !cmd_q[CMD_RUN_B]);
    // R2: the controller never runs while it is not ready
    assert_ready_before_run_R2: assert property (@(posedge clk) disable iff (rst)
        run_enable |-> !not_ready);
    // R8: a full reset in progress keeps the controller stopped
    assert_full_rst_stopped_R8: assert property (@(posedge clk) disable iff (rst)
        full_busy |-> (!run_enable && halted));

endmodule

// File: tb/sim_hc_cmdsts.sv
module sim_hc_cmdsts;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic fatal_evt = 0, event_evt = 0, port_evt = 0, hce_evt = 0, db_req = 0;
    logic db_accept, run_enable, core_rst;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hc_cmdsts u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .fatal_evt(fatal_evt), .event_evt(event_evt), .port_evt(port_evt),
        .hce_evt(hce_evt), .db_req(db_req), .db_accept(db_accept),
        .run_enable(run_enable), .core_rst(core_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_raddr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [1:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ev(input logic [1:0] a, input logic [31:0] d,
                         input logic fe, input logic ee, input logic pe);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        fatal_evt = fe; event_evt = ee; port_evt = pe;
        @(negedge clk);
        reg_wr = 1'b0; fatal_evt = 0; event_evt = 0; port_evt = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_ev(a, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic pulse(input logic fe, input logic ee, input logic pe, input logic he);
        @(negedge clk);
        fatal_evt = fe; event_evt = ee; port_evt = pe; hce_evt = he;
        @(negedge clk);
        fatal_evt = 0; event_evt = 0; port_evt = 0; hce_evt = 0;
    endtask

    task automatic t_reset_window;
        @(negedge clk);
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        chk_reg("R1 cmd after reset", 2'd0, 32'h0);
        chk_reg("R1 sts after reset", 2'd1, 32'h801);
        chk("R1 run_enable", {31'b0, run_enable}, 32'h0);
        chk("R1 core_rst", {31'b0, core_rst}, 32'h0);
        db_req = 1'b1;
        #1 chk("R2 doorbell blocked", {31'b0, db_accept}, 32'h0);
        reg_wr = 1'b1; reg_waddr = 2'd0; reg_wdata = 32'h1;
        @(negedge clk);
        reg_wr = 1'b0;
        chk_reg("R2 write ignored while not ready", 2'd0, 32'h0);
        idle(30);
        chk_reg("R2 not-ready at edge 31", 2'd1, 32'h801);
        idle(1);
        chk_reg("R2 ready at edge 32", 2'd1, 32'h1);
        #1 chk("R2 doorbell accepted", {31'b0, db_accept}, 32'h1);
        db_req = 1'b0;
    endtask

    task automatic t_run_stop;
        wr(2'd0, 32'h1);
        chk("R3 run_enable not yet", {31'b0, run_enable}, 32'h0);
        idle(1);
        chk("R3 run_enable up", {31'b0, run_enable}, 32'h1);
        chk_reg("R3 halted cleared", 2'd1, 32'h0);
        wr(2'd0, 32'h0);
        idle(1);
        chk("R4 run_enable down", {31'b0, run_enable}, 32'h0);
        idle(15);
        chk_reg("R4 not halted at 15", 2'd1, 32'h0);
        idle(1);
        chk_reg("R4 halted at 16", 2'd1, 32'h1);
    endtask

    task automatic t_fatal;
        wr_ev(2'd0, 32'h1, 1'b1, 1'b0, 1'b0);
        chk_reg("R5 fatal beats run write (cmd)", 2'd0, 32'h0);
        chk_reg("R5 fatal flag", 2'd1, 32'h5);
        idle(1);
        chk("R5 never runs", {31'b0, run_enable}, 32'h0);
        wr(2'd1, 32'h4);
        chk_reg("R7 fatal cleared", 2'd1, 32'h1);
        wr(2'd0, 32'h1);
        idle(1);
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        chk_reg("R5 run cleared by fatal", 2'd0, 32'h0);
        idle(1);
        chk("R5 run_enable drops", {31'b0, run_enable}, 32'h0);
        idle(16);
        chk_reg("R5 halted after drain", 2'd1, 32'h5);
        wr(2'd1, 32'h4);
    endtask

    task automatic t_flags;
        pulse(1'b0, 1'b1, 1'b0, 1'b0);
        chk_reg("R6 event flag", 2'd1, 32'h9);
        pulse(1'b0, 1'b0, 1'b1, 1'b0);
        chk_reg("R6 port flag", 2'd1, 32'h19);
        wr(2'd1, 32'h0);
        chk_reg("R7 write 0 no effect", 2'd1, 32'h19);
        wr(2'd1, 32'h8);
        chk_reg("R7 clear event only", 2'd1, 32'h11);
        wr_ev(2'd1, 32'h18, 1'b0, 1'b1, 1'b0);
        chk_reg("R7 set wins, port cleared", 2'd1, 32'h9);
        wr(2'd1, 32'h8);
    endtask

    task automatic t_reserved;
        wr(2'd0, 32'hFFFF_FF7C);
        chk_reg("R10 reserved read 0", 2'd0, 32'h0000_0F0C);
        wr(2'd0, 32'h0000_0104);
        chk_reg("R10 storage readback", 2'd0, 32'h0000_0104);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_light;
        pulse(1'b0, 1'b0, 1'b0, 1'b1);
        chk_reg("R11 hce set", 2'd1, 32'h1001);
        wr(2'd1, 32'h1000);
        chk_reg("R11 hce not w1c", 2'd1, 32'h1001);
        wr(2'd0, 32'h1);
        idle(1);
        pulse(1'b0, 1'b1, 1'b0, 1'b0);
        wr(2'd0, 32'h81);
        chk_reg("R9 light bit reads 1", 2'd0, 32'h80);
        chk("R9 core_rst", {31'b0, core_rst}, 32'h1);
        chk("R9 halted at once", {31'b0, run_enable}, 32'h0);
        chk_reg("R9 flags cleared, hce kept", 2'd1, 32'h1001);
        idle(7);
        chk_reg("R9 light bit at 7", 2'd0, 32'h80);
        idle(1);
        chk_reg("R9 light bit self-clears", 2'd0, 32'h0);
        chk("R9 core_rst off", {31'b0, core_rst}, 32'h0);
        chk_reg("R11 hce survives light reset", 2'd1, 32'h1001);
    endtask

    task automatic t_full;
        wr(2'd0, 32'h1);
        idle(1);
        wr(2'd0, 32'h3);
        chk_reg("R8 reset bit reads 1", 2'd0, 32'h2);
        chk_reg("R8 status during reset", 2'd1, 32'h801);
        chk("R8 core_rst", {31'b0, core_rst}, 32'h1);
        chk("R8 stopped", {31'b0, run_enable}, 32'h0);
        idle(7);
        chk_reg("R8 reset bit at 7", 2'd0, 32'h2);
        idle(1);
        chk_reg("R8 reset bit self-clears", 2'd0, 32'h0);
        chk_reg("R8 not-ready follows", 2'd1, 32'h801);
        idle(31);
        chk_reg("R2 not-ready at 31 after sequence", 2'd1, 32'h801);
        idle(1);
        chk_reg("R2 ready at 32 after sequence", 2'd1, 32'h1);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_window();
        t_run_stop();
        t_fatal();
        t_flags();
        t_reserved();
        t_light();
        t_full();
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule